// File: doc/BRIEF.md
# Parallel Translate-and-Index Lookup Unit

This block answers one memory request per cycle by running address translation and cache indexing side by side. The untranslated low part of the virtual address selects a line in a direct-mapped 4 KB cache of single-word lines. In the same cycle, the upper part of the address searches a small fully associative translation buffer. The physical page that comes out of the buffer is then compared with the tag stored in the selected line. The result goes into one registered response. That response reports one of four outcomes: a hit with data, a cache miss with a usable physical address, a translation miss, or a permission fault.

Translations are installed through a refill port, which replaces entries in rotating order. Cache lines are installed through a line fill port, which is addressed by physical line address. The translation buffer tracks a referenced flag and a modified flag for each entry and reports both with each response. Loads and stores that hit are served in the cache. Stores that are not allowed by the entry's rights do not change anything.

Top module: `vipt_lookup`

## Requirements
- R1: Each cycle with `req_valid` high gives exactly one response with `rsp_valid` high on the next cycle. A cycle without a request gives `rsp_valid` low on the next cycle.
- R2: The virtual address splits into a page number in bits [31:12] and a page offset in bits [11:0]. The line index is bits [11:2]. The reported physical address is {physical page, virtual bits [11:0]}, and the byte offset bits [1:0] pass through unchanged.
- R3: When no valid translation entry matches the page number, `rsp_kind` is 2'b10. `rsp_paddr`, `rsp_data`, `rsp_dirty` and `rsp_refd` are then all zero.
- R4: `rsp_kind` is 2'b00 (hit) only when the indexed line is valid and its stored tag equals the physical page from the translation. A load hit returns the whole stored word on `rsp_data`.
- R5: When the translation hits but the line is invalid or its tag differs, `rsp_kind` is 2'b01 and `rsp_paddr` carries the translated address.
- R6: The rights field is 2 bits: bit 1 permits stores and bit 0 permits loads. An access without the matching permission gives `rsp_kind` 2'b11 with the translated address. It leaves the cache contents and the modified flag unchanged.
- R7: Every translation hit sets the entry's referenced flag. `rsp_refd` shows the flag as it stands after the access.
- R8: A permitted store sets the entry's modified flag, whether it hits or misses in the cache. `rsp_dirty` shows the flag as it stands after the access.
- R9: A permitted store that hits replaces the whole line word. A store that misses does not allocate a line. `rsp_data` is zero for every store.
- R10: The translation buffer has 8 entries. After reset, refills go to entry 0 and then to each following entry in turn, wrapping back to entry 0 after entry 7. A refill sets the valid flag and clears the modified and referenced flags.
- R11: A line fill writes the data, sets the valid flag, and sets the tag to the upper 20 bits of the physical line address, at the index given by its lower 10 bits.
- R12: During and right after reset there is no response, and every translation entry and every cache line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual byte address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| tlb_wr_en | input | 1 | Install a translation |
| tlb_wr_vpn | input | 20 | Virtual page of the new entry |
| tlb_wr_ppn | input | 20 | Physical page of the new entry |
| tlb_wr_rights | input | 2 | Rights of the new entry (bit 1 store, bit 0 load) |
| fill_en | input | 1 | Install a cache line |
| fill_line_addr | input | 30 | Physical line address (tag in [29:10], index in [9:0]) |
| fill_data | input | 32 | Line word |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 00 hit, 01 cache miss, 10 translation miss, 11 fault |
| rsp_data | output | 32 | Load hit data, else zero |
| rsp_paddr | output | 32 | Translated byte address, zero on translation miss |
| rsp_dirty | output | 1 | Modified flag of the matched entry after the access |
| rsp_refd | output | 1 | Referenced flag of the matched entry after the access |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4 KB pages, single-word lines and eight translation entries. With these values the line index sits wholly inside the page offset. Two virtual pages that map to one physical page therefore reach the same line, and the bench shows that through a hit after re-mapping. Eight entries make the wrap of the rotating refill pointer reachable with nine refills. The bench then sees the oldest mapping disappear while a younger one stays.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [1:0] {
        RSP_HIT   = 2'b00,
        RSP_CMISS = 2'b01,
        RSP_TMISS = 2'b10,
        RSP_FAULT = 2'b11
    } rsp_kind_e;

    localparam int RIGHT_LOAD  = 0;
    localparam int RIGHT_STORE = 1;
    localparam int RIGHTS_W    = 2;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb
    import vipt_pkg::*;
#(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_en,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic                lk_store,
    output logic                lk_hit,
    output logic [PPN_W-1:0]    lk_ppn,
    output logic [RIGHTS_W-1:0] lk_rights,
    output logic                lk_dirty,
    output logic                lk_refd,
    input  logic                wr_en,
    input  logic [VPN_W-1:0]    wr_vpn,
    input  logic [PPN_W-1:0]    wr_ppn,
    input  logic [RIGHTS_W-1:0] wr_rights
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

    typedef struct packed {
        logic                valid;
        logic [VPN_W-1:0]    vpn;
        logic [PPN_W-1:0]    ppn;
        logic [RIGHTS_W-1:0] rights;
        logic                dirty;
        logic                refd;
    } tlb_ent_t;

    tlb_ent_t         ent_q [N];
    tlb_ent_t         ent_d [N];
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [N-1:0]     match;
    logic [PTR_W-1:0] hit_idx;
    tlb_ent_t         hit_ent;
    logic             st_ok;

    // parallel compare of every entry against the page number
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_q[g].valid && (ent_q[g].vpn == lk_vpn);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_idx = PTR_W'(i);
        end
    end

    assign hit_ent   = ent_q[hit_idx];
    assign lk_hit    = |match;
    assign lk_ppn    = lk_hit ? hit_ent.ppn : '0;
    assign lk_rights = lk_hit ? hit_ent.rights : '0;
    assign st_ok     = lk_store && hit_ent.rights[RIGHT_STORE];
    assign lk_dirty  = lk_hit && (hit_ent.dirty || st_ok);
    assign lk_refd   = lk_hit;

    always_comb begin
        for (int i = 0; i < N; i++) ent_d[i] = ent_q[i];
        ptr_d = ptr_q;
        if (lk_en && lk_hit) begin
            ent_d[hit_idx].refd = 1'b1;
            if (st_ok) ent_d[hit_idx].dirty = 1'b1;
        end
        if (wr_en) begin
            ent_d[ptr_q].valid  = 1'b1;
            ent_d[ptr_q].vpn    = wr_vpn;
            ent_d[ptr_q].ppn    = wr_ppn;
            ent_d[ptr_q].rights = wr_rights;
            ent_d[ptr_q].dirty  = 1'b0;
            ent_d[ptr_q].refd   = 1'b0;
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
            ptr_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) ent_q[i] <= ent_d[i];
            ptr_q <= ptr_d;
        end
    end

    // R10: refill pointer steps by one and wraps
    p_rr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

    // R10: pointer holds without a refill
    p_rr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr_q));

    // R2: at most one entry translates a page
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              st_en,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [DATA_W-1:0] st_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q, valid_d;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    always_comb begin
        valid_d = valid_q;
        if (fill_en) valid_d[fill_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // storage arrays carry no reset; a fill wins over a store to the same line
    always_ff @(posedge clk) begin
        if (st_en) data_q[st_idx] <= st_data;
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_data;
        end
    end

    // R11: a filled line reads back valid with its tag
    p_fill_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag));

    // R9: a store only targets a line that is already valid
    p_store_on_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> valid_q[st_idx]);
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PG_W   = 12,
    parameter int OFF_W  = 2,
    parameter int PPN_W  = 20,
    parameter int TLB_N  = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_store,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  tlb_wr_en,
    input  logic [VA_W-PG_W-1:0]  tlb_wr_vpn,
    input  logic [PPN_W-1:0]      tlb_wr_ppn,
    input  logic [1:0]            tlb_wr_rights,
    input  logic                  fill_en,
    input  logic [PPN_W+PG_W-OFF_W-1:0] fill_line_addr,
    input  logic [DATA_W-1:0]     fill_data,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_kind,
    output logic [DATA_W-1:0]     rsp_data,
    output logic [PPN_W+PG_W-1:0] rsp_paddr,
    output logic                  rsp_dirty,
    output logic                  rsp_refd
);
    localparam int VPN_W = VA_W - PG_W;
    localparam int IDX_W = PG_W - OFF_W;
    localparam int PA_W  = PPN_W + PG_W;

    typedef struct packed {
        logic              valid;
        rsp_kind_e         kind;
        logic [DATA_W-1:0] data;
        logic [PA_W-1:0]   paddr;
        logic              dirty;
        logic              refd;
    } rsp_t;

    rsp_t rsp_q, rsp_d;

    logic [VPN_W-1:0]    vpn;
    logic [IDX_W-1:0]    idx;
    logic                t_hit, t_dirty, t_refd;
    logic [PPN_W-1:0]    t_ppn;
    logic [RIGHTS_W-1:0] t_rights;
    logic                c_valid;
    logic [PPN_W-1:0]    c_tag;
    logic [DATA_W-1:0]   c_data;
    logic                allowed, line_hit, st_en;

    assign vpn = req_vaddr[VA_W-1:PG_W];
    assign idx = req_vaddr[PG_W-1:OFF_W];

    vipt_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_en     (req_valid),
        .lk_vpn    (vpn),
        .lk_store  (req_store),
        .lk_hit    (t_hit),
        .lk_ppn    (t_ppn),
        .lk_rights (t_rights),
        .lk_dirty  (t_dirty),
        .lk_refd   (t_refd),
        .wr_en     (tlb_wr_en),
        .wr_vpn    (tlb_wr_vpn),
        .wr_ppn    (tlb_wr_ppn),
        .wr_rights (tlb_wr_rights)
    );

    vipt_cache #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx),
        .rd_valid  (c_valid),
        .rd_tag    (c_tag),
        .rd_data   (c_data),
        .st_en     (st_en),
        .st_idx    (idx),
        .st_data   (req_wdata),
        .fill_en   (fill_en),
        .fill_idx  (fill_line_addr[IDX_W-1:0]),
        .fill_tag  (fill_line_addr[IDX_W+PPN_W-1:IDX_W]),
        .fill_data (fill_data)
    );

    assign allowed  = req_store ? t_rights[RIGHT_STORE] : t_rights[RIGHT_LOAD];
    assign line_hit = c_valid && (c_tag == t_ppn);
    assign st_en    = req_valid && req_store && t_hit && allowed && line_hit;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.kind  = RSP_TMISS;
        if (req_valid && t_hit) begin
            rsp_d.paddr = {t_ppn, req_vaddr[PG_W-1:0]};
            rsp_d.dirty = t_dirty;
            rsp_d.refd  = t_refd;
            if (!allowed) begin
                rsp_d.kind = RSP_FAULT;
            end else if (line_hit) begin
                rsp_d.kind = RSP_HIT;
                rsp_d.data = req_store ? '0 : c_data;
            end else begin
                rsp_d.kind = RSP_CMISS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_kind  = rsp_q.kind;
    assign rsp_data  = rsp_q.data;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_dirty = rsp_q.dirty;
    assign rsp_refd  = rsp_q.refd;

    // R1: one response per request, one cycle later
    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: a translation miss reports nothing else
    p_tmiss_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_TMISS) |-> (rsp_paddr == '0 && rsp_data == '0 && !rsp_dirty && !rsp_refd));

    // R7: any translated response shows the referenced flag
    p_refd_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != RSP_TMISS) |-> rsp_refd);

    // R2: the page offset passes through untranslated
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && t_hit) |=> rsp_paddr[PG_W-1:0] == $past(req_vaddr[PG_W-1:0]));

    // R6: a fault never writes the cache
    p_fault_no_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && t_hit && !allowed) |-> !st_en);
endmodule

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb;
    typedef struct {
        logic [1:0]  kind;
        logic [31:0] data;
        logic [31:0] paddr;
        logic        dirty;
        logic        refd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        tlb_wr_en = 1'b0;
    logic [19:0] tlb_wr_vpn = '0;
    logic [19:0] tlb_wr_ppn = '0;
    logic [1:0]  tlb_wr_rights = '0;
    logic        fill_en = 1'b0;
    logic [29:0] fill_line_addr = '0;
    logic [31:0] fill_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_data;
    logic [31:0] rsp_paddr;
    logic        rsp_dirty;
    logic        rsp_refd;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb [$];

    always #5 clk = ~clk;

    vipt_lookup u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_store(req_store), .req_wdata(req_wdata),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn), .tlb_wr_rights(tlb_wr_rights),
        .fill_en(fill_en), .fill_line_addr(fill_line_addr), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty), .rsp_refd(rsp_refd)
    );

    // driver: push the expected response, then present the request for one cycle
    task automatic access(input logic [31:0] va, input logic st, input logic [31:0] wd,
                          input logic [1:0] k, input logic [31:0] pa, input logic [31:0] d,
                          input logic dy, input logic rf, input string tag);
        exp_t e;
        @(negedge clk);
        e.kind = k; e.data = d; e.paddr = pa; e.dirty = dy; e.refd = rf; e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1; req_vaddr = va; req_store = st; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vp, input logic [19:0] pp, input logic [1:0] rt);
        @(negedge clk);
        tlb_wr_en = 1'b1; tlb_wr_vpn = vp; tlb_wr_ppn = pp; tlb_wr_rights = rt;
        @(negedge clk);
        tlb_wr_en = 1'b0;
    endtask

    task automatic fill(input logic [31:0] pa, input logic [31:0] d);
        @(negedge clk);
        fill_en = 1'b1; fill_line_addr = pa[31:2]; fill_data = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // monitor: compare each response with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R1: unexpected response actual kind=%b expected none", rsp_kind);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_kind !== e.kind || rsp_data !== e.data || rsp_paddr !== e.paddr ||
                    rsp_dirty !== e.dirty || rsp_refd !== e.refd) begin
                    n_fail++;
                    $display("FAIL %s: actual kind=%b data=%h pa=%h d=%b r=%b expected kind=%b data=%h pa=%h d=%b r=%b",
                             e.tag, rsp_kind, rsp_data, rsp_paddr, rsp_dirty, rsp_refd,
                             e.kind, e.data, e.paddr, e.dirty, e.refd);
                end
            end
        end
    end

    task automatic check_idle(input string tag);
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: actual rsp_valid=%b expected 0", tag, rsp_valid);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R12 reset");
        rst_n = 1'b1;
        check_idle("R12 after reset");

        access(32'h0000_5123, 0, 0, 2'b10, 32'h0, 32'h0, 0, 0, "R3 empty buffer");
        refill(20'h00005, 20'h000A7, 2'b11);
        refill(20'h00006, 20'h00033, 2'b01);
        refill(20'h00007, 20'h000A8, 2'b11);
        access(32'h0000_5124, 0, 0, 2'b01, 32'h000A_7124, 32'h0, 0, 1, "R5 invalid line");
        fill(32'h000A_7124, 32'hDEAD_BEEF);
        access(32'h0000_5125, 0, 0, 2'b00, 32'h000A_7125, 32'hDEAD_BEEF, 0, 1, "R4 R11 load hit");
        access(32'h0000_7124, 0, 0, 2'b01, 32'h000A_8124, 32'h0, 0, 1, "R5 tag mismatch");
        access(32'h0000_5124, 1, 32'h1122_3344, 2'b00, 32'h000A_7124, 32'h0, 1, 1, "R8 store hit");
        access(32'h0000_5124, 0, 0, 2'b00, 32'h000A_7124, 32'h1122_3344, 1, 1, "R9 store data");
        fill(32'h0003_3010, 32'h0000_0055);
        access(32'h0000_6010, 1, 32'h99, 2'b11, 32'h0003_3010, 32'h0, 0, 1, "R6 store fault");
        access(32'h0000_6010, 0, 0, 2'b00, 32'h0003_3010, 32'h55, 0, 1, "R6 line untouched");
        access(32'h0000_7200, 1, 32'h77, 2'b01, 32'h000A_8200, 32'h0, 1, 1, "R8 store miss");
        access(32'h0000_7200, 0, 0, 2'b01, 32'h000A_8200, 32'h0, 1, 1, "R9 no allocate");
        check_idle("R1 idle");
        refill(20'h00010, 20'h00001, 2'b11);
        refill(20'h00011, 20'h00002, 2'b11);
        refill(20'h00012, 20'h00003, 2'b00);
        refill(20'h00013, 20'h00004, 2'b11);
        refill(20'h00014, 20'h00005, 2'b11);
        access(32'h0001_2000, 0, 0, 2'b11, 32'h0000_3000, 32'h0, 0, 1, "R6 load fault");
        refill(20'h00020, 20'h000A7, 2'b11);
        access(32'h0000_5124, 0, 0, 2'b10, 32'h0, 32'h0, 0, 0, "R10 oldest evicted");
        access(32'h0000_6010, 0, 0, 2'b00, 32'h0003_3010, 32'h55, 0, 1, "R10 second kept");
        access(32'h0002_0124, 0, 0, 2'b00, 32'h000A_7124, 32'h1122_3344, 0, 1, "R2 R7 R10 remapped page");
        access(32'h0002_0124, 1, 32'hCAFE_0001, 2'b00, 32'h000A_7124, 32'h0, 1, 1, "R8 first store");

        repeat (3) @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R1: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule